// File: doc/BRIEF.md
# Runtime-Signed Partitioned Multiplier

This block is a two-stage pipelined multiplier built on one pair of 72-bit operand buses. A quasi-static size select splits the datapath into eight 9x9 lanes, four 18x18 lanes or one 36x36 lane. Two runtime flags, one for each operand, say whether every A operand and every B operand in the beat is two's complement or unsigned. Each flag applies to all active lanes at once. The flags travel through the pipeline with the data they qualify. Every product is full precision, twice the lane width, and the results are packed from bit 0 of a 144-bit result bus upward.

The A operand register can also load as a shift chain instead of from the parallel bus. In that mode each lane takes the previous lane's registered A value, and lane 0 takes a scan port. The B operand always loads in parallel.

Operands enter on a valid/ready stream and products leave on a valid/ready stream. The pipeline moves as a whole. When the output holds a beat that the sink has not taken, nothing advances and `in_ready` is low. A beat moves only on a clock edge where `ce` is high and `clr` is low. `clr` empties the whole pipeline. `cfg_size` and `cfg_shift` may change only while the block holds no beat.

Top module: `rmul_array`

## Requirements
- R1: With `cfg_size`=00, lane i (i=0..7) multiplies A bits [9i+8:9i] by B bits [9i+8:9i] and places the 18-bit product at `out_prod`[18i+17:18i].
- R2: With `cfg_size`=01, lane j (j=0..3) multiplies A bits [18j+17:18j] by B bits [18j+17:18j] and places the 36-bit product at `out_prod`[36j+35:36j].
- R3: With `cfg_size`=1x, A bits [35:0] times B bits [35:0] gives a 72-bit product at `out_prod`[71:0]. `out_prod`[143:72] is zero, and operand bits [71:36] have no effect.
- R4: `sign_a`=1 treats each A lane operand as two's complement, and 0 treats it as unsigned. `sign_b` does the same for B. Each product is the exact full-width result for all four flag combinations.
- R5: `out_signed` equals `sign_a` OR `sign_b` as captured with the beat it accompanies.
- R6: A beat accepted at an edge, with `ce` high and `out_ready` high throughout, shows `out_valid` at the second following edge and not at the first. Beats leave in order, with none lost and none added.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_prod` and `out_signed` hold their values.
- R8: With `cfg_shift`=1 in the 9 or 18 sizes, each accepted beat shifts the A register up by one lane and loads lane 0 from `scan_in` (its low 9 bits in the 9x9 size). In the 36 size `cfg_shift` has no effect.
- R9: While `ce` is low, `in_ready` is low and all outputs hold their values.
- R10: One cycle with `clr` high drops every beat in flight. After that edge `out_valid` and `out_prod` are zero, and the A shift register is cleared.
- R11: After reset, `out_valid`, `out_prod` and `out_signed` are zero, and `in_ready` follows `ce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock enable for every register |
| clr | input | 1 | Synchronous clear of the whole pipeline |
| cfg_size | input | 2 | Lane size: 00 = 9x9, 01 = 18x18, 1x = 36x36 |
| cfg_shift | input | 1 | A operand loads from the lane shift chain |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Operand beat taken at this edge |
| in_a | input | 72 | Operand A lanes |
| in_b | input | 72 | Operand B lanes |
| sign_a | input | 1 | A operands are two's complement |
| sign_b | input | 1 | B operands are two's complement |
| scan_in | input | 18 | Lane 0 source in shift mode |
| out_valid | output | 1 | Product beat present |
| out_ready | input | 1 | Sink takes the product beat |
| out_prod | output | 144 | Packed lane products |
| out_signed | output | 1 | Products are to be read as signed |

## Verification
A stuck or stale sign register changes the upper bits of the products for the very next beat. That shows at the output two accepted edges later. A shift chain that skips or repeats a lane shows up as shifted lane products within one beat of the fault, so the bench compares every lane of every beat against its own model. A corrupted valid bit shows as an extra, missing or reordered beat by the second edge. The stall, clock-enable and clear cases are checked at the ports in the cycles where a fault would show first.

// File: rtl/rmul_pkg.sv
package rmul_pkg;

  typedef enum logic [1:0] {
    SZ_9  = 2'b00,
    SZ_18 = 2'b01,
    SZ_36 = 2'b10
  } size_e;

  // Upper select bit wins; 11 is read as the widest size.
  function automatic size_e decode_size(input logic [1:0] code);
    if (code[1])      return SZ_36;
    else if (code[0]) return SZ_18;
    else              return SZ_9;
  endfunction

endpackage

// File: rtl/rmul_in_stage.sv
module rmul_in_stage
  import rmul_pkg::*;
#(
  parameter int BASE_W = 9,
  parameter int N_BASE = 8,
  localparam int BUS_W  = BASE_W * N_BASE,
  localparam int SCAN_W = 2 * BASE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic              in_valid,
  input  size_e             size,
  input  logic              shift,
  input  logic [BUS_W-1:0]  in_a,
  input  logic [BUS_W-1:0]  in_b,
  input  logic              sign_a,
  input  logic              sign_b,
  input  logic [SCAN_W-1:0] scan_in,
  output logic              v_q,
  output logic [BUS_W-1:0]  a_q,
  output logic [BUS_W-1:0]  b_q,
  output logic              sa_q,
  output logic              sb_q,
  output size_e             size_q
);

  logic [BUS_W-1:0] a_next;

  // Shift chain: lane i takes lane i-1, lane 0 takes the scan port.
  always_comb begin
    a_next = in_a;
    if (shift) begin
      unique case (size)
        SZ_9:    a_next = {a_q[BUS_W-BASE_W-1:0], scan_in[BASE_W-1:0]};
        SZ_18:   a_next = {a_q[BUS_W-SCAN_W-1:0], scan_in};
        default: a_next = in_a;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
      sa_q   <= 1'b0;
      sb_q   <= 1'b0;
      size_q <= SZ_9;
    end else if (clr) begin
      v_q    <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
      sa_q   <= 1'b0;
      sb_q   <= 1'b0;
      size_q <= SZ_9;
    end else if (adv) begin
      v_q <= in_valid;
      if (in_valid) begin
        a_q    <= a_next;
        b_q    <= in_b;
        sa_q   <= sign_a;
        sb_q   <= sign_b;
        size_q <= size;
      end
    end
  end

endmodule

// File: rtl/rmul_lane.sv
module rmul_lane #(
  parameter int W = 9,
  localparam int PW = 2 * W
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          sa,
  input  logic          sb,
  output logic [PW-1:0] p
);

  // Unsigned operands get zero fill, signed ones sign fill; the product
  // taken modulo 2^PW is exact for every sign combination.
  logic signed [PW-1:0] ax;
  logic signed [PW-1:0] bx;
  logic signed [PW-1:0] full;

  assign ax   = $signed({{W{sa & a[W-1]}}, a});
  assign bx   = $signed({{W{sb & b[W-1]}}, b});
  assign full = ax * bx;
  assign p    = full;

endmodule

// File: rtl/rmul_core.sv
module rmul_core
  import rmul_pkg::*;
#(
  parameter int BASE_W = 9,
  parameter int N_BASE = 8,
  localparam int BUS_W  = BASE_W * N_BASE,
  localparam int PROD_W = 2 * BUS_W
) (
  input  size_e             size,
  input  logic [BUS_W-1:0]  a,
  input  logic [BUS_W-1:0]  b,
  input  logic              sa,
  input  logic              sb,
  output logic [PROD_W-1:0] prod
);

  // Tier 0: base lanes, tier 1: double lanes, tier 2: one quad lane.
  for (genvar g = 0; g < 3; g++) begin : g_tier
    localparam int W    = BASE_W << g;
    localparam int CNT  = (g == 2) ? 1 : (N_BASE >> g);
    localparam int USED = CNT * 2 * W;
    logic [PROD_W-1:0] p;

    for (genvar i = 0; i < CNT; i++) begin : g_lane
      rmul_lane #(.W(W)) u_lane (
        .a  (a[i*W +: W]),
        .b  (b[i*W +: W]),
        .sa (sa),
        .sb (sb),
        .p  (p[i*2*W +: 2*W])
      );
    end

    if (USED < PROD_W) begin : g_pad
      assign p[PROD_W-1:USED] = '0;
    end
  end

  always_comb begin
    unique case (size)
      SZ_9:    prod = g_tier[0].p;
      SZ_18:   prod = g_tier[1].p;
      default: prod = g_tier[2].p;
    endcase
  end

endmodule

// File: rtl/rmul_array.sv
module rmul_array
  import rmul_pkg::*;
#(
  parameter int BASE_W = 9,
  parameter int N_BASE = 8,
  localparam int BUS_W  = BASE_W * N_BASE,
  localparam int PROD_W = 2 * BUS_W,
  localparam int SCAN_W = 2 * BASE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              clr,
  input  logic [1:0]        cfg_size,
  input  logic              cfg_shift,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BUS_W-1:0]  in_a,
  input  logic [BUS_W-1:0]  in_b,
  input  logic              sign_a,
  input  logic              sign_b,
  input  logic [SCAN_W-1:0] scan_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PROD_W-1:0] out_prod,
  output logic              out_signed
);

  logic              adv;
  logic              v1;
  logic [BUS_W-1:0]  a_q;
  logic [BUS_W-1:0]  b_q;
  logic              sa_q;
  logic              sb_q;
  size_e             size_q;
  logic [PROD_W-1:0] core_prod;
  logic              v2;
  logic [PROD_W-1:0] p_q;
  logic              sg_q;

  // Whole pipeline moves together; a held output stalls both stages.
  assign adv      = ce & ~clr & (~v2 | out_ready);
  assign in_ready = adv;

  rmul_in_stage #(.BASE_W(BASE_W), .N_BASE(N_BASE)) u_in (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .adv      (adv),
    .in_valid (in_valid),
    .size     (decode_size(cfg_size)),
    .shift    (cfg_shift),
    .in_a     (in_a),
    .in_b     (in_b),
    .sign_a   (sign_a),
    .sign_b   (sign_b),
    .scan_in  (scan_in),
    .v_q      (v1),
    .a_q      (a_q),
    .b_q      (b_q),
    .sa_q     (sa_q),
    .sb_q     (sb_q),
    .size_q   (size_q)
  );

  rmul_core #(.BASE_W(BASE_W), .N_BASE(N_BASE)) u_core (
    .size (size_q),
    .a    (a_q),
    .b    (b_q),
    .sa   (sa_q),
    .sb   (sb_q),
    .prod (core_prod)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2   <= 1'b0;
      p_q  <= '0;
      sg_q <= 1'b0;
    end else if (clr) begin
      v2   <= 1'b0;
      p_q  <= '0;
      sg_q <= 1'b0;
    end else if (adv) begin
      v2 <= v1;
      if (v1) begin
        p_q  <= core_prod;
        sg_q <= sa_q | sb_q;
      end
    end
  end

  assign out_valid  = v2;
  assign out_prod   = p_q;
  assign out_signed = sg_q;

endmodule

// File: rtl/rmul_array_chk.sv
module rmul_array_chk #(
  parameter int PROD_W = 144
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce,
  input logic              clr,
  input logic [1:0]        cfg_size,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PROD_W-1:0] out_prod,
  input logic              out_signed
);

  // R7: a stalled beat holds its value
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !clr |=> out_valid && $stable(out_prod) && $stable(out_signed));

  // R7: no intake while the output is blocked
  a_r7_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R9: clock enable low freezes the outputs
  a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !ce && !clr |=> $stable(out_valid) && $stable(out_prod) && $stable(out_signed));

  // R10: clear empties the output stage
  a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !out_valid && (out_prod == '0));

  // R3: the upper half is zero in the widest size
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_size[1] |-> (out_prod[PROD_W-1:PROD_W/2] == '0));

endmodule

bind rmul_array rmul_array_chk #(.PROD_W(PROD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce         (ce),
  .clr        (clr),
  .cfg_size   (cfg_size),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_prod   (out_prod),
  .out_signed (out_signed)
);

// File: tb/rmul_array_bench.sv
module rmul_array_bench;

  localparam int BUS_W  = 72;
  localparam int PROD_W = 144;
  localparam int SCAN_W = 18;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ce = 1'b1;
  logic              clr = 1'b0;
  logic [1:0]        cfg_size = 2'b00;
  logic              cfg_shift = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [BUS_W-1:0]  in_a = '0;
  logic [BUS_W-1:0]  in_b = '0;
  logic              sign_a = 1'b0;
  logic              sign_b = 1'b0;
  logic [SCAN_W-1:0] scan_in = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [PROD_W-1:0] out_prod;
  logic              out_signed;

  rmul_array u_rmul_array (
    .clk(clk), .rst_n(rst_n), .ce(ce), .clr(clr), .cfg_size(cfg_size),
    .cfg_shift(cfg_shift), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .sign_a(sign_a), .sign_b(sign_b),
    .scan_in(scan_in), .out_valid(out_valid), .out_ready(out_ready),
    .out_prod(out_prod), .out_signed(out_signed)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_tag = "R1";
  logic [PROD_W:0]  exp_q[$];
  string            tag_q[$];
  logic [BUS_W-1:0] model_a = '0;
  logic [PROD_W-1:0] saved;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [PROD_W-1:0] act, input logic [PROD_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic int sz_of(input logic [1:0] c);
    return c[1] ? 2 : (c[0] ? 1 : 0);
  endfunction

  // Reference: lane-by-lane exact multiply from the requirements.
  function automatic logic [PROD_W-1:0] ref_mul(input int sz, input logic [BUS_W-1:0] a,
      input logic [BUS_W-1:0] b, input logic sa, input logic sb);
    int w;
    int n;
    logic [PROD_W-1:0] r;
    logic signed [73:0] xa;
    logic signed [73:0] xb;
    logic signed [73:0] pr;
    w = 9 << sz;
    n = (sz == 2) ? 1 : (8 >> sz);
    r = '0;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 74; k++) begin
        xa[k] = (k < w) ? a[i*w+k] : (sa & a[i*w+w-1]);
        xb[k] = (k < w) ? b[i*w+k] : (sb & b[i*w+w-1]);
      end
      pr = xa * xb;
      for (int k = 0; k < 2*w; k++) r[i*2*w+k] = pr[k];
    end
    return r;
  endfunction

  function automatic logic [BUS_W-1:0] rnd72();
    logic [95:0] t;
    t = {$urandom, $urandom, $urandom};
    return t[BUS_W-1:0];
  endfunction

  task automatic scoreboard();
    logic [PROD_W:0] e;
    string t;
    int sz;
    if (clr) begin
      exp_q.delete();
      tag_q.delete();
      model_a = '0;
    end else if (ce) begin
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", "extra beat", out_prod, '0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_prod == e[PROD_W-1:0], t, "product", out_prod, e[PROD_W-1:0]);
          check(out_signed == e[PROD_W], "R5", "signed flag",
                PROD_W'(out_signed), PROD_W'(e[PROD_W]));
        end
      end
      if (in_valid && in_ready) begin
        sz = sz_of(cfg_size);
        if (cfg_shift && sz == 0)      model_a = {model_a[BUS_W-10:0], scan_in[8:0]};
        else if (cfg_shift && sz == 1) model_a = {model_a[BUS_W-19:0], scan_in};
        else                           model_a = in_a;
        exp_q.push_back({sign_a | sign_b, ref_mul(sz, model_a, in_b, sign_a, sign_b)});
        tag_q.push_back(cur_tag);
      end
    end
  endtask

  task automatic tick();
    #1;
    scoreboard();
    @(negedge clk);
  endtask

  task automatic drain();
    in_valid = 1'b0; out_ready = 1'b1; ce = 1'b1; clr = 1'b0;
    for (int i = 0; i < 30 && exp_q.size() > 0; i++) tick();
    check(exp_q.size() == 0, "R6", "beats missing", PROD_W'(exp_q.size()), '0);
    tick();
  endtask

  task automatic send(input logic [BUS_W-1:0] a, input logic [BUS_W-1:0] b,
                      input logic sa, input logic sb);
    in_valid = 1'b1; in_a = a; in_b = b; sign_a = sa; sign_b = sb;
    tick();
    in_valid = 1'b0;
  endtask

  task automatic run_random(input logic [1:0] size, input logic shift, input int n,
                            input string tag);
    logic [31:0] t;
    cfg_size = size; cfg_shift = shift; cur_tag = tag;
    for (int i = 0; i < n; i++) begin
      in_valid  = ($urandom % 4) != 0;
      out_ready = ($urandom % 4) != 0;
      ce        = ($urandom % 8) != 0;
      in_a = rnd72();
      in_b = rnd72();
      if ($urandom % 8 == 0) in_a = '1;
      if ($urandom % 8 == 0) in_b = {8{9'h100}};
      sign_a = $urandom % 2 == 1;
      sign_b = $urandom % 2 == 1;
      t = $urandom;
      scan_in = t[SCAN_W-1:0];
      tick();
    end
    drain();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R11", "out_valid after reset", PROD_W'(out_valid), '0);
    check(out_prod == '0, "R11", "out_prod after reset", out_prod, '0);
    check(out_signed == 1'b0, "R11", "out_signed after reset", PROD_W'(out_signed), '0);
    check(in_ready == 1'b1, "R11", "in_ready after reset", PROD_W'(in_ready), 1);
    @(negedge clk);

    // R6 latency and a hand-computed R4 value: -1 (signed) times 511 (unsigned)
    cur_tag = "R4";
    cfg_size = 2'b00;
    send({8{9'h1FF}}, {8{9'h1FF}}, 1'b1, 1'b0);
    #1;
    check(out_valid == 1'b0, "R6", "valid one edge after accept", PROD_W'(out_valid), '0);
    tick();
    #1;
    check(out_valid == 1'b1, "R6", "valid two edges after accept", PROD_W'(out_valid), 1);
    check(out_prod == {8{18'h3FE01}}, "R4", "-1 x 511 lanes", out_prod, {8{18'h3FE01}});
    check(out_signed == 1'b1, "R5", "mixed sign flag", PROD_W'(out_signed), 1);
    drain();

    // R4 corners in all sizes
    cfg_size = 2'b00;
    send({8{9'h100}}, {8{9'h100}}, 1'b1, 1'b1);
    send({8{9'h1FF}}, {8{9'h1FF}}, 1'b0, 1'b0);
    send({8{9'h100}}, {8{9'h1FF}}, 1'b0, 1'b1);
    drain();
    cfg_size = 2'b01;
    send({4{18'h20000}}, {4{18'h20000}}, 1'b1, 1'b1);
    send({4{18'h3FFFF}}, {4{18'h3FFFF}}, 1'b0, 1'b0);
    send({4{18'h3FFFF}}, {4{18'h20000}}, 1'b0, 1'b1);
    drain();
    cfg_size = 2'b10;
    send({36'hABCDE1234, 36'h800000000}, {36'h555555555, 36'h800000000}, 1'b1, 1'b1);
    send({36'h0, 36'hFFFFFFFFF}, {36'h0, 36'hFFFFFFFFF}, 1'b0, 1'b0);
    send({36'h0, 36'hFFFFFFFFF}, {36'h0, 36'h7FFFFFFFF}, 1'b1, 1'b0);
    drain();

    // R7 back-pressure
    cur_tag = "R7";
    cfg_size = 2'b00;
    out_ready = 1'b0;
    in_valid = 1'b1; in_a = rnd72(); in_b = rnd72(); sign_a = 1'b0; sign_b = 1'b1;
    tick();
    in_a = rnd72();
    tick();
    #1;
    saved = out_prod;
    for (int i = 0; i < 3; i++) begin
      check(in_ready == 1'b0, "R7", "in_ready while blocked", PROD_W'(in_ready), '0);
      check(out_valid == 1'b1 && out_prod == saved, "R7", "held product", out_prod, saved);
      tick();
      #1;
    end
    drain();

    // R9 clock enable low
    cur_tag = "R9";
    out_ready = 1'b0;
    send(rnd72(), rnd72(), 1'b1, 1'b0);
    out_ready = 1'b0;
    tick();
    #1;
    saved = out_prod;
    ce = 1'b0; out_ready = 1'b1; in_valid = 1'b1; in_a = rnd72();
    for (int i = 0; i < 3; i++) begin
      tick();
      #1;
      check(in_ready == 1'b0, "R9", "in_ready with ce low", PROD_W'(in_ready), '0);
      check(out_valid == 1'b1 && out_prod == saved, "R9", "frozen output", out_prod, saved);
    end
    drain();

    // R10 clear drops beats in flight
    cur_tag = "R10";
    out_ready = 1'b0;
    in_valid = 1'b1; in_a = rnd72(); in_b = rnd72();
    tick();
    tick();
    in_valid = 1'b0; clr = 1'b1;
    tick();
    clr = 1'b0;
    #1;
    check(out_valid == 1'b0, "R10", "out_valid after clear", PROD_W'(out_valid), '0);
    check(out_prod == '0, "R10", "out_prod after clear", out_prod, '0);
    out_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      #1;
      check(out_valid == 1'b0, "R10", "no beat after clear", PROD_W'(out_valid), '0);
    end
    drain();

    // R8 directed shift chain after clear: A register starts at zero
    cur_tag = "R8";
    cfg_size = 2'b00; cfg_shift = 1'b1;
    for (int k = 0; k < 9; k++) begin
      scan_in = SCAN_W'(k * 37 + 1);
      send(rnd72(), {8{9'h003}}, 1'b0, 1'b0);
    end
    drain();
    cfg_size = 2'b01;
    for (int k = 0; k < 5; k++) begin
      scan_in = SCAN_W'(k * 9001 + 7);
      send(rnd72(), {4{18'h2FFFF}}, 1'b1, 1'b1);
    end
    drain();

    // Random phases
    run_random(2'b00, 1'b0, 300, "R1");
    run_random(2'b01, 1'b0, 300, "R2");
    run_random(2'b10, 1'b0, 300, "R3");
    run_random(2'b11, 1'b0, 100, "R3");
    run_random(2'b00, 1'b1, 200, "R8");
    run_random(2'b01, 1'b1, 200, "R8");
    run_random(2'b10, 1'b1, 100, "R8");
    run_random(2'b00, 1'b0, 200, "R4");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule